// File: doc/BRIEF.md
# Loadable Binary Counter with Decade Mode

This block is a synchronous up-counter that can be preset from a data input and advanced by an enable. A mode pin selects plain binary counting across the full range, or decade counting. In decade mode the state steps from zero to nine and then returns to zero.

The return to zero goes through the same synchronous next-state path that an external preset uses, and it is triggered when the state is nine. No asynchronous clear is used, so the state ten never shows on the outputs, even briefly. The carry output is combinational. Several counters can be chained by feeding each carry into the next stage's count enable, for example three decades to count from 0 to 999.

The block moves no data stream, so every pin is a plain level signal with no handshake.

Top module: `loadable_decade_counter`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, `q` becomes 0 after that edge, whatever the other inputs are.
- R2: With `rst`=0 and `load_en`=1, `q` takes `load_val` at the edge. This holds for any `count_en` and either mode.
- R3: With `load_en`=0 and `count_en`=1, `q` increases by one at the edge. In binary mode (`dec_mode`=0) the state wraps from all ones to 0.
- R4: With `load_en`=0 and `count_en`=0, `q` keeps its value.
- R5: In binary mode, `carry_out` is 1 exactly when `q` is all ones, whatever `count_en` is.
- R6: In decade mode (`dec_mode`=1), counting from 9 (binary 1001) gives 0. The counting sequence is 0,1,...,9,0.
- R7: In decade mode, counting from any value from 0 to 9 never produces a value above 9. In particular, 10 (binary 1010) never appears.
- R8: In decade mode, `carry_out` is 1 exactly when `q` is 9 and `count_en` is 1.
- R9: `load_en` wins over the decade return to zero. At `q`=9 in decade mode, with `load_en`=1 and `count_en`=1, `q` takes `load_val`.
- R10: In decade mode, a loaded value above 9 counts up in binary. It wraps from 15 to 0 and then follows the decade sequence. `carry_out` stays 0 while such a value is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Preset enable, highest priority after reset |
| count_en | input | 1 | Increment enable |
| load_val | input | WIDTH (4) | Preset value |
| dec_mode | input | 1 | 0 = binary counting, 1 = decade counting |
| q | output | WIDTH (4) | Counter state |
| carry_out | output | 1 | Terminal-count flag used for cascading |

## Verification
The bench builds the counter with its default parameters: a 4-bit state, a decade limit of 9 and decade logic present. With this build every one of the sixteen states can be reached. That includes the six values above nine in decade mode, which can only be entered by a preset. Binary wrap, the decade return to zero, the priority of the preset at nine, and the carry under each combination of mode and enable can all be exercised directly at the ports.

// File: rtl/counter_pkg.sv
package counter_pkg;
  typedef enum logic {
    MODE_BINARY = 1'b0,
    MODE_DECADE = 1'b1
  } count_mode_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_LOAD   = 2'd1,
    ACT_INCR   = 2'd2,
    ACT_RELOAD = 2'd3
  } count_action_e;
endpackage

// File: rtl/cnt_action_sel.sv
module cnt_action_sel
  import counter_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter int DEC_LAST   = 9,
  parameter bit HAS_DECADE = 1'b1
) (
  input  logic [WIDTH-1:0] q,
  input  logic             load_en,
  input  logic             count_en,
  input  count_mode_e      mode,
  output count_action_e    action
);
  localparam logic [WIDTH-1:0] LAST_V = WIDTH'(DEC_LAST);

  logic at_last;

  generate
    if (HAS_DECADE) begin : g_dec
      assign at_last = (mode == MODE_DECADE) && (q == LAST_V);
    end else begin : g_nodec
      assign at_last = 1'b0;
    end
  endgenerate

  // Priority: preset, then terminal reload, then increment, else hold.
  always_comb begin
    if (load_en)       action = ACT_LOAD;
    else if (!count_en) action = ACT_HOLD;
    else if (at_last)  action = ACT_RELOAD;
    else               action = ACT_INCR;
  end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg
  import counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  count_action_e    action,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] d;

  always_comb begin
    unique case (action)
      ACT_LOAD:   d = load_val;
      ACT_INCR:   d = q + WIDTH'(1);
      ACT_RELOAD: d = '0;
      default:    d = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  // R1: reset empties the state
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (q == '0));
  // R4: hold leaves the state alone
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (action == ACT_HOLD) |=> $stable(q));
  // R2: preset takes the data input
  a_r2_load_taken: assert property (@(posedge clk) disable iff (rst)
    (action == ACT_LOAD) |=> (q == $past(load_val)));
endmodule

// File: rtl/cnt_carry.sv
module cnt_carry
  import counter_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter int DEC_LAST   = 9,
  parameter bit HAS_DECADE = 1'b1
) (
  input  logic [WIDTH-1:0] q,
  input  logic             count_en,
  input  count_mode_e      mode,
  output logic             carry
);
  localparam logic [WIDTH-1:0] LAST_V = WIDTH'(DEC_LAST);

  logic bin_carry;
  logic dec_carry;

  assign bin_carry = &q;

  generate
    if (HAS_DECADE) begin : g_dec
      assign dec_carry = count_en && (q == LAST_V);
    end else begin : g_nodec
      assign dec_carry = 1'b0;
    end
  endgenerate

  assign carry = (HAS_DECADE && mode == MODE_DECADE) ? dec_carry : bin_carry;
endmodule

// File: rtl/loadable_decade_counter.sv
module loadable_decade_counter
  import counter_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter int DEC_LAST   = 9,
  parameter bit HAS_DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic             count_en,
  input  logic [WIDTH-1:0] load_val,
  input  logic             dec_mode,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] LAST_V = WIDTH'(DEC_LAST);

  count_mode_e   mode;
  count_action_e action;

  assign mode = count_mode_e'(dec_mode);

  cnt_action_sel #(.WIDTH(WIDTH), .DEC_LAST(DEC_LAST), .HAS_DECADE(HAS_DECADE)) u_sel (
    .q(q), .load_en(load_en), .count_en(count_en), .mode(mode), .action(action)
  );

  cnt_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk(clk), .rst(rst), .action(action), .load_val(load_val), .q(q)
  );

  cnt_carry #(.WIDTH(WIDTH), .DEC_LAST(DEC_LAST), .HAS_DECADE(HAS_DECADE)) u_carry (
    .q(q), .count_en(count_en), .mode(mode), .carry(carry_out)
  );

  // R3: increment step
  a_r3_increment: assert property (@(posedge clk) disable iff (rst)
    (!load_en && count_en && !(dec_mode && q == LAST_V)) |=> (q == $past(q) + WIDTH'(1)));
  // R6: decade return to zero
  a_r6_decade_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load_en && count_en && dec_mode && q == LAST_V) |=> (q == '0));
  // R7: decade range is closed under counting
  a_r7_no_ten: assert property (@(posedge clk) disable iff (rst)
    (!load_en && count_en && dec_mode && q <= LAST_V) |=> (q <= LAST_V));
  // R8: decade carry needs the enable
  a_r8_carry_needs_en: assert property (@(posedge clk) disable iff (rst)
    (dec_mode && carry_out) |-> (count_en && q == LAST_V));
  // R5: binary carry only at all ones
  a_r5_bin_carry: assert property (@(posedge clk) disable iff (rst)
    (!dec_mode && carry_out) |-> (&q));
endmodule

// File: tb/loadable_decade_counter_tb.sv
module loadable_decade_counter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_en = 1'b0;
  logic       count_en = 1'b0;
  logic [3:0] load_val = 4'd0;
  logic       dec_mode = 1'b0;
  logic [3:0] q;
  logic       carry_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  loadable_decade_counter u_dut (
    .clk(clk), .rst(rst), .load_en(load_en), .count_en(count_en),
    .load_val(load_val), .dec_mode(dec_mode), .q(q), .carry_out(carry_out)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // advance one edge, then settle away from it
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_in(input logic ld, input logic ce, input logic [3:0] v, input logic dm);
    load_en = ld; count_en = ce; load_val = v; dec_mode = dm;
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    set_in(1'b1, 1'b1, 4'd5, 1'b0);
    tick();
    chk("R1 reset clears", q, 0);
    rst = 1'b0;
    set_in(1'b0, 1'b0, 4'd0, 1'b0);
  endtask

  task automatic t_load();
    set_in(1'b1, 1'b1, 4'd10, 1'b0);
    tick();
    chk("R2 load binary", q, 10);
    set_in(1'b1, 1'b0, 4'd12, 1'b1);
    tick();
    chk("R2 load decade", q, 12);
  endtask

  task automatic t_binary();
    set_in(1'b1, 1'b0, 4'd13, 1'b0);
    tick();
    set_in(1'b0, 1'b1, 4'd0, 1'b0);
    chk("R5 carry at 13", carry_out, 0);
    tick();
    chk("R3 13->14", q, 14);
    chk("R5 carry at 14", carry_out, 0);
    tick();
    chk("R3 14->15", q, 15);
    chk("R5 carry at 15", carry_out, 1);
    set_in(1'b0, 1'b0, 4'd0, 1'b0);
    chk("R5 carry at 15 no enable", carry_out, 1);
    set_in(1'b0, 1'b1, 4'd0, 1'b0);
    tick();
    chk("R3 wrap 15->0", q, 0);
  endtask

  task automatic t_hold();
    set_in(1'b1, 1'b0, 4'd6, 1'b1);
    tick();
    set_in(1'b0, 1'b0, 4'd3, 1'b1);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R4 hold", q, 6);
    end
  endtask

  task automatic t_decade();
    set_in(1'b1, 1'b0, 4'd0, 1'b1);
    tick();
    set_in(1'b0, 1'b1, 4'd0, 1'b1);
    for (int i = 0; i < 12; i++) begin
      chk("R8 carry", carry_out, (i % 10) == 9);
      tick();
      chk("R6 decade seq", q, (i + 1) % 10);
      chk("R7 at most 9", q <= 4'd9, 1);
    end
    // now at 2; load 9 and check carry without enable
    set_in(1'b1, 1'b0, 4'd9, 1'b1);
    tick();
    set_in(1'b0, 1'b0, 4'd0, 1'b1);
    chk("R8 carry off without enable", carry_out, 0);
    set_in(1'b0, 1'b1, 4'd0, 1'b1);
    chk("R8 carry on at 9", carry_out, 1);
  endtask

  task automatic t_priority();
    set_in(1'b1, 1'b0, 4'd9, 1'b1);
    tick();
    set_in(1'b1, 1'b1, 4'd3, 1'b1);
    tick();
    chk("R9 load beats reload", q, 3);
  endtask

  task automatic t_over();
    set_in(1'b1, 1'b0, 4'd14, 1'b1);
    tick();
    set_in(1'b0, 1'b1, 4'd0, 1'b1);
    chk("R10 carry at 14", carry_out, 0);
    tick();
    chk("R10 14->15", q, 15);
    chk("R10 carry at 15", carry_out, 0);
    tick();
    chk("R10 15->0", q, 0);
    tick();
    chk("R10 0->1", q, 1);
  endtask

  initial begin
    #1;
    t_reset();
    t_load();
    t_binary();
    t_hold();
    t_decade();
    t_priority();
    t_over();
    t_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule